// File: doc/BRIEF.md
# Receive Character Queue with Fill Threshold

This block holds received serial characters until software or a downstream engine collects them. It is a synchronous first-in first-out store of sixteen slots. Each slot keeps an 8-bit character together with three per-character error marks: a break mark, a parity-error mark and a framing-error mark. The front end of a serial receiver pushes one character at a time. The consumer pops characters in arrival order. The block reports its occupancy, empty and full status, a level output that rises once a programmable number of characters is waiting, an overrun pulse when a character arrives with no room, and a summary flag that is high while any waiting character carries an error mark.

The threshold is chosen by a 2-bit selector. It lets an interrupt source wait for a batch of characters instead of reacting to each one. A synchronous clear empties the queue in one cycle without touching the storage array. The array is a plain memory with no reset, so it can map onto distributed RAM.

Top module: `rx_char_fifo`

## Requirements
- R1: While reset is held and on the first cycle after it, `count` is 0, `empty` is 1, `full` is 0, `trig` is 0, `overrun` is 0 and `err_any` is 0.
- R2: Characters leave in the order they were pushed, each with its own three marks. `push_marks` and `pop_marks` both use bit 2 for break, bit 1 for parity error and bit 0 for framing error. An accepted pop loads the oldest entry into `pop_data`/`pop_marks` at that clock edge.
- R3: An accepted push alone raises `count` by one and an accepted pop alone lowers it by one. `empty` is high exactly when `count` is 0, and `full` is high exactly when `count` is 16.
- R4: A push and a pop in the same cycle on a non-empty queue leave `count` unchanged and neither lose nor duplicate a character. This includes the full case, where the push is accepted.
- R5: A push while full with no pop is dropped. The stored contents and `count` stay unchanged, and `overrun` is high for exactly the one cycle after that edge.
- R6: A pop while empty is ignored, and `pop_data`/`pop_marks` keep their previous value.
- R7: `trig` is high whenever `count` is at or above the threshold chosen by `trig_sel`: 2'b00 selects 1, 2'b01 selects 4, 2'b10 selects 8 and 2'b11 selects 14. It follows `trig_sel` without a clock delay.
- R8: `clr` takes priority over push and pop in its cycle. After that edge `count` is 0 and `err_any` is 0, and the output register is not altered.
- R9: `err_any` is high while at least one stored character has any of its three marks set, and low otherwise.
- R10: A push and a pop together on an empty queue accept only the push. `count` becomes 1 and the output register is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous queue clear |
| push | input | 1 | Write request |
| push_data | input | 8 | Character to store |
| push_marks | input | 3 | Error marks of the character {break, parity, framing} |
| pop | input | 1 | Read request |
| pop_data | output | 8 | Last character popped |
| pop_marks | output | 3 | Marks of the last character popped |
| trig_sel | input | 2 | Threshold select |
| count | output | 5 | Occupancy, 0 to 16 |
| empty | output | 1 | Queue holds nothing |
| full | output | 1 | Queue holds 16 |
| trig | output | 1 | Occupancy at or above threshold |
| overrun | output | 1 | One-cycle pulse for a dropped push |
| err_any | output | 1 | A stored character carries an error mark |

## Verification
The bound checker watches occupancy on every cycle. It checks that `count` stays within bounds, steps by one on a lone push, holds under a paired push and pop, and holds at full when a push is dropped. It also checks that `overrun` appears only after a dropped push, that a pop on an empty queue leaves the output register alone, and that a clear empties the queue and drops `err_any`. Only the bench scenarios can show that character order and marks survive interleaved traffic. They also show that the dropped character never reappears after draining a full queue, that every threshold code matches the count, and that `err_any` tracks marked entries as they move through the queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int MARK_W = 3;
   localparam int MARK_BRK = 2;
   localparam int MARK_PAR = 1;
   localparam int MARK_FRM = 0;

   typedef enum logic [1:0] {
      LVL_A = 2'b00,
      LVL_B = 2'b01,
      LVL_C = 2'b10,
      LVL_D = 2'b11
   } lvl_sel_e;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
   parameter int DEPTH = 16,
   parameter int PTR_W = $clog2(DEPTH),
   parameter int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             pop,
   output logic             wr_en,
   output logic             rd_en,
   output logic [PTR_W-1:0] wptr,
   output logic [PTR_W-1:0] rptr,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             full,
   output logic             overrun
);
   localparam bit POW2 = (DEPTH == (1 << PTR_W));

   logic [PTR_W-1:0] wptr_nx, rptr_nx;

   assign empty = (count == '0);
   assign full  = (count == CNT_W'(DEPTH));
   assign rd_en = pop && !empty && !clr;
   assign wr_en = push && !clr && (!full || rd_en);

   generate
      if (POW2) begin : g_wrap_free
         assign wptr_nx = wptr + PTR_W'(1);
         assign rptr_nx = rptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + PTR_W'(1);
         assign rptr_nx = (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         overrun <= push && full && !rd_en && !clr;
         if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
         end else begin
            if (wr_en) wptr <= wptr_nx;
            if (rd_en) rptr <= rptr_nx;
            case ({wr_en, rd_en})
               2'b10:   count <= count + CNT_W'(1);
               2'b01:   count <= count - CNT_W'(1);
               default: count <= count;
            endcase
         end
      end
   end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int W     = 11,
   parameter int DEPTH = 16,
   parameter int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] waddr,
   input  logic [W-1:0]     wdata,
   input  logic             rd_en,
   input  logic [PTR_W-1:0] raddr,
   output logic [W-1:0]     rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= mem[raddr];
   end
endmodule

// File: rtl/rxq_errtrack.sv
module rxq_errtrack #(
   parameter int DEPTH = 16,
   parameter int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] waddr,
   input  logic             wr_err,
   input  logic             rd_en,
   input  logic [PTR_W-1:0] raddr,
   output logic             err_any
);
   logic [DEPTH-1:0] slot_err;

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  slot_err[s] <= 1'b0;
            else if (clr)                                slot_err[s] <= 1'b0;
            else if (wr_en && waddr == PTR_W'(s))        slot_err[s] <= wr_err;
            else if (rd_en && raddr == PTR_W'(s))        slot_err[s] <= 1'b0;
         end
      end
   endgenerate

   assign err_any = |slot_err;
endmodule

// File: rtl/rxq_trig.sv
module rxq_trig #(
   parameter int CNT_W = 5,
   parameter int LVL0  = 1,
   parameter int LVL1  = 4,
   parameter int LVL2  = 8,
   parameter int LVL3  = 14
) (
   input  logic [CNT_W-1:0] count,
   input  logic [1:0]       sel,
   output logic             trig
);
   import rxq_pkg::*;
   logic [CNT_W-1:0] thr;

   always_comb begin
      case (lvl_sel_e'(sel))
         LVL_A:   thr = CNT_W'(LVL0);
         LVL_B:   thr = CNT_W'(LVL1);
         LVL_C:   thr = CNT_W'(LVL2);
         default: thr = CNT_W'(LVL3);
      endcase
   end

   assign trig = (count >= thr);
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int LVL0   = 1,
   parameter int LVL1   = 4,
   parameter int LVL2   = 8,
   parameter int LVL3   = 14
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             clr,
   input  logic                             push,
   input  logic [DATA_W-1:0]                push_data,
   input  logic [rxq_pkg::MARK_W-1:0]       push_marks,
   input  logic                             pop,
   output logic [DATA_W-1:0]                pop_data,
   output logic [rxq_pkg::MARK_W-1:0]       pop_marks,
   input  logic [1:0]                       trig_sel,
   output logic [$clog2(DEPTH):0]           count,
   output logic                             empty,
   output logic                             full,
   output logic                             trig,
   output logic                             overrun,
   output logic                             err_any
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;
   localparam int ENT_W = DATA_W + rxq_pkg::MARK_W;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_char_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_char_fifo: DATA_W must be positive");
      end
      if (LVL0 < 1 || LVL1 < 1 || LVL2 < 1 || LVL3 < 1 ||
          LVL0 > DEPTH || LVL1 > DEPTH || LVL2 > DEPTH || LVL3 > DEPTH) begin : g_bad_lvl
         $error("rx_char_fifo: thresholds must lie in 1..DEPTH");
      end
   endgenerate

   logic             wr_en, rd_en;
   logic [PTR_W-1:0] wptr, rptr;
   logic [ENT_W-1:0] rd_word;

   rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .pop(pop),
      .wr_en(wr_en), .rd_en(rd_en), .wptr(wptr), .rptr(rptr),
      .count(count), .empty(empty), .full(full), .overrun(overrun)
   );

   rxq_store #(.W(ENT_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(wptr),
      .wdata({push_marks, push_data}), .rd_en(rd_en), .raddr(rptr),
      .rdata(rd_word)
   );

   rxq_errtrack #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_err (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .waddr(wptr),
      .wr_err(|push_marks), .rd_en(rd_en), .raddr(rptr), .err_any(err_any)
   );

   rxq_trig #(.CNT_W(CNT_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)) u_trig (
      .count(count), .sel(trig_sel), .trig(trig)
   );

   assign pop_data  = rd_word[DATA_W-1:0];
   assign pop_marks = rd_word[ENT_W-1:DATA_W];
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         clr,
   input logic                         push,
   input logic                         pop,
   input logic [DATA_W-1:0]            pop_data,
   input logic [$clog2(DEPTH):0]       count,
   input logic                         empty,
   input logic                         full,
   input logic                         overrun,
   input logic                         err_any
);
   localparam int CNT_W = $clog2(DEPTH) + 1;

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R3
   push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !full && !clr) |=> count == $past(count) + CNT_W'(1));

   // R4
   pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !empty && !clr) |=> count == $past(count));

   // R5
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> (count == CNT_W'(DEPTH)) && overrun);

   // R5
   overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(push && full && !pop && !clr));

   // R6
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !clr) |=> $stable(pop_data));

   // R8
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0) && !err_any);
endmodule

bind rx_char_fifo rxq_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .pop(pop),
   .pop_data(pop_data), .count(count), .empty(empty), .full(full),
   .overrun(overrun), .err_any(err_any)
);

// File: tb/tb_rx_char_fifo.sv
module tb_rx_char_fifo;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0, push = 1'b0, pop = 1'b0;
   logic [7:0] push_data = '0;
   logic [2:0] push_marks = '0;
   logic [1:0] trig_sel = '0;
   logic [7:0] pop_data;
   logic [2:0] pop_marks;
   logic [4:0] count;
   logic       empty, full, trig, overrun, err_any;

   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   rx_char_fifo dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .push_data(push_data),
      .push_marks(push_marks), .pop(pop), .pop_data(pop_data), .pop_marks(pop_marks),
      .trig_sel(trig_sel), .count(count), .empty(empty), .full(full), .trig(trig),
      .overrun(overrun), .err_any(err_any)
   );

   typedef struct packed {
      logic       ps;
      logic       pp;
      logic [7:0] d;
      logic [2:0] m;
      logic [4:0] ecnt;
      logic [7:0] ed;
      logic [2:0] em;
      logic       eerr;
   } step_t;

   // marks: bit2 break, bit1 parity, bit0 framing
   localparam step_t TBL [10] = '{
      '{1'b1, 1'b0, 8'hA1, 3'b000, 5'd1, 8'h00, 3'b000, 1'b0},
      '{1'b1, 1'b0, 8'hB2, 3'b100, 5'd2, 8'h00, 3'b000, 1'b1},
      '{1'b1, 1'b0, 8'hC3, 3'b000, 5'd3, 8'h00, 3'b000, 1'b1},
      '{1'b0, 1'b1, 8'h00, 3'b000, 5'd2, 8'hA1, 3'b000, 1'b1},
      '{1'b1, 1'b1, 8'hD4, 3'b010, 5'd2, 8'hB2, 3'b100, 1'b1},
      '{1'b0, 1'b1, 8'h00, 3'b000, 5'd1, 8'hC3, 3'b000, 1'b1},
      '{1'b0, 1'b1, 8'h00, 3'b000, 5'd0, 8'hD4, 3'b010, 1'b0},
      '{1'b0, 1'b1, 8'h00, 3'b000, 5'd0, 8'hD4, 3'b010, 1'b0},
      '{1'b1, 1'b1, 8'hE5, 3'b001, 5'd1, 8'hD4, 3'b010, 1'b1},
      '{1'b0, 1'b1, 8'h00, 3'b000, 5'd0, 8'hE5, 3'b001, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic ps, input logic pp, input logic [7:0] d, input logic [2:0] m);
      @(negedge clk);
      push = ps; pop = pp; push_data = d; push_marks = m;
      @(negedge clk);
      push = 1'b0; pop = 1'b0;
   endtask

   function automatic int thr_of(input int s);
      case (s)
         0: return 1;
         1: return 4;
         2: return 8;
         default: return 14;
      endcase
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 during reset and after release
      chk(count == 0 && empty && !full && !trig && !overrun && !err_any, "R1", count, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(count == 0 && empty && !full && !trig && !overrun && !err_any, "R1", count, 0);

      // R2 R3 R4 R6 R9 R10 table walk
      foreach (TBL[i]) begin
         cyc(TBL[i].ps, TBL[i].pp, TBL[i].d, TBL[i].m);
         chk(count == TBL[i].ecnt && empty == (TBL[i].ecnt == 0), "R3/R4/R10 count", count, TBL[i].ecnt);
         if (TBL[i].pp)
            chk({pop_marks, pop_data} == {TBL[i].em, TBL[i].ed}, "R2/R6 popped entry",
                {pop_marks, pop_data}, {TBL[i].em, TBL[i].ed});
         chk(err_any == TBL[i].eerr, "R9 err_any", err_any, TBL[i].eerr);
      end

      // R3 R7 fill to full, checking every threshold code at each level
      for (int i = 0; i < 16; i++) begin
         cyc(1'b1, 1'b0, 8'h10 + 8'(i), 3'b000);
         chk(count == 5'(i + 1), "R3 fill count", count, i + 1);
         for (int s = 0; s < 4; s++) begin
            trig_sel = 2'(s);
            #1;
            chk(trig == (i + 1 >= thr_of(s)), "R7 trig", trig, (i + 1 >= thr_of(s)));
         end
      end
      chk(full && !empty, "R3 full flag", full, 1);

      // R5 push while full is dropped, one-cycle overrun
      @(negedge clk);
      push = 1'b1; push_data = 8'hEE; push_marks = 3'b111;
      @(negedge clk);
      push = 1'b0;
      chk(overrun == 1'b1 && count == 16, "R5 overrun pulse", overrun, 1);
      chk(err_any == 1'b0, "R5 contents unchanged", err_any, 0);
      @(negedge clk);
      chk(overrun == 1'b0, "R5 pulse one cycle", overrun, 0);

      // R4 push and pop together while full
      cyc(1'b1, 1'b1, 8'h77, 3'b000);
      chk(count == 16 && !overrun, "R4 full pair count", count, 16);
      chk(pop_data == 8'h10, "R4 full pair data", pop_data, 8'h10);

      // R2 R5 drain: dropped character never appears
      for (int i = 1; i < 16; i++) begin
         cyc(1'b0, 1'b1, 8'h00, 3'b000);
         chk(pop_data == 8'h10 + 8'(i), "R2 drain order", pop_data, 8'h10 + i);
      end
      cyc(1'b0, 1'b1, 8'h00, 3'b000);
      chk(pop_data == 8'h77 && empty, "R5 dropped char absent", pop_data, 8'h77);

      // R9 marked entry, then R8 clear with simultaneous push
      cyc(1'b1, 1'b0, 8'h55, 3'b100);
      chk(err_any == 1'b1 && count == 1, "R9 err set", err_any, 1);
      @(negedge clk);
      clr = 1'b1; push = 1'b1; push_data = 8'h66; push_marks = 3'b010;
      @(negedge clk);
      clr = 1'b0; push = 1'b0;
      chk(count == 0 && empty && !err_any, "R8 clear", count, 0);
      chk(pop_data == 8'h77, "R8 output kept", pop_data, 8'h77);

      // R6 pop on empty after clear
      cyc(1'b0, 1'b1, 8'h00, 3'b000);
      chk(pop_data == 8'h77 && count == 0, "R6 empty pop", pop_data, 8'h77);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule